// File: doc/BRIEF.md
# Prescaled Cycle Counter

This block keeps a 64-bit count of processor cycles for a performance-monitoring unit. Each clock it receives a cycle delta together with an enable and a filter-pass qualifier. When both are high the delta is added to the count. In divide mode the delta first goes through a 6-bit remainder accumulator, so the count advances once for every 64 qualified cycles and no fraction is lost between clocks.

The counter can be zeroed by a pulse or loaded with a full 64-bit value. A zero or load takes priority over counting in the same cycle. Overflow is a falling most-significant bit across an addition, with the bit chosen by a width select: bit 31 or bit 63. On overflow the block pulses an overflow-detect output. When the shared overflow-status bit, supplied from outside, is still clear, it also pulses a status-set output, and it pulses the interrupt request if the interrupt enable is high.

A small type register goes with the counter. It keeps the filter flags written to it, and it always reads back the fixed cycle event number.

Top module: `prescaled_cycle_counter`

## Requirements
- R1: After reset, `value_o` is 0, the remainder is 0, the divide-mode history is 0, `ovf_o`, `ovf_set_o` and `irq_o` are 0, and `type_rdata_o` reads 0x0000_0011.
- R2: With `en_i` and `pass_i` high and `div64_i` low, `value_o` increases by `delta_i` on the next clock edge.
- R3: If `en_i` or `pass_i` is low, the delta is dropped. Neither the counter nor the remainder changes.
- R4: In divide mode with counting allowed, s = remainder + `delta_i`. The counter advances by s >> 6 and the remainder becomes s mod 64. With `div64_i` low the remainder holds.
- R5: The remainder is cleared when `rem_clr_i` is high, or when `div64_i` differs from its value in the previous cycle. That cycle's delta is then added onto a remainder of 0.
- R6: `zero_i` sets the counter to 0 on the next edge. It overrides `load_i` and counting, and that cycle's delta is dropped.
- R7: `load_i` without `zero_i` loads `load_val_i` into the counter. That cycle's delta is dropped and no overflow is reported.
- R8: `ovf_o` pulses for one cycle, in the cycle the new value appears, when an addition takes the selected bit from 1 to 0. The selected bit is 63 when `wide_i` is 1 and 31 when it is 0.
- R9: `ovf_set_o` pulses with `ovf_o` only if `ovf_sts_i` was 0 in the cycle of the addition.
- R10: `irq_o` pulses for one cycle with `ovf_set_o` only if `irq_en_i` was 1 in the cycle of the addition.
- R11: A write through `type_wr_i` stores `type_wdata_i[31:24]` as filter flags. `type_rdata_o` reads the flags in bits 31:24, 0 in bits 23:8, and the fixed event number 0x11 in bits 7:0, whatever was written to the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| pass_i | input | 1 | Filter result; 1 allows counting |
| delta_i | input | 8 | Cycles elapsed this clock |
| div64_i | input | 1 | Divide-by-64 mode |
| rem_clr_i | input | 1 | Clears the remainder |
| zero_i | input | 1 | Zeroes the counter |
| load_i | input | 1 | Loads `load_val_i` into the counter |
| load_val_i | input | 64 | Value to load |
| wide_i | input | 1 | 1 selects 64-bit overflow, 0 selects 32-bit overflow |
| ovf_sts_i | input | 1 | Current shared overflow-status bit |
| irq_en_i | input | 1 | Interrupt enable for this counter |
| type_wr_i | input | 1 | Type register write strobe |
| type_wdata_i | input | 32 | Type register write data |
| value_o | output | 64 | Counter value |
| ovf_o | output | 1 | Overflow-detect pulse |
| ovf_set_o | output | 1 | Pulse that sets the shared status bit |
| irq_o | output | 1 | Interrupt request pulse |
| type_rdata_o | output | 32 | Type register read data |

## Verification
The assertions check on every cycle the priority of zero over load and counting, exact loading, a frozen value while counting is not allowed, remainder clearing, the storing of the filter flags, and the chain in which an interrupt implies a status set and a status set implies an overflow. The bench's scenarios are the only way to show the remainder arithmetic across many deltas. That covers a remainder kept through suppressed cycles, clearing on a mode toggle versus carry-over, the choice between the 32-bit and 64-bit overflow points, and suppression of the status set and the interrupt when the status bit or enable forbids them.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;
  localparam int unsigned CNT_W    = 64;
  localparam int unsigned DIV_SH   = 6;
  localparam int unsigned TYPE_W   = 32;
  localparam int unsigned EVT_W    = 8;
  localparam int unsigned FLT_W    = 8;
  localparam int unsigned NARROW_W = 32;
  localparam logic [EVT_W-1:0] CYCLE_EVT = 8'h11;
endpackage

// File: rtl/ccnt_prescale.sv
module ccnt_prescale #(
  parameter int unsigned DELTA_W = 8,
  parameter int unsigned SH      = ccnt_pkg::DIV_SH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               count_i,
  input  logic               div64_i,
  input  logic               rem_clr_i,
  input  logic [DELTA_W-1:0] delta_i,
  output logic [DELTA_W-1:0] inc_o
);
  localparam int unsigned SUM_W = DELTA_W + 1;

  logic [SH-1:0]    rem_q, rem_base;
  logic             div_q;
  logic [SUM_W-1:0] sum;

  // mode toggle or explicit clear restarts the fraction
  always_comb begin
    rem_base = (rem_clr_i || (div64_i != div_q)) ? '0 : rem_q;
    sum      = {1'b0, delta_i} + SUM_W'(rem_base);
    inc_o    = div64_i ? DELTA_W'(sum >> SH) : delta_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      div_q <= 1'b0;
    end else begin
      div_q <= div64_i;
      rem_q <= (count_i && div64_i) ? sum[SH-1:0] : rem_base;
    end
  end

  p_rem_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_clr_i && !count_i) |=> (rem_q == '0));

  p_rem_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_i && !rem_clr_i && div64_i && $past(div64_i)) |=> $stable(rem_q));
endmodule

// File: rtl/ccnt_accum.sv
module ccnt_accum #(
  parameter int unsigned CNT_W = ccnt_pkg::CNT_W,
  parameter int unsigned INC_W = 8,
  parameter int unsigned NAR_W = ccnt_pkg::NARROW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             zero_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             wide_i,
  output logic [CNT_W-1:0] value_o,
  output logic             ovf_hit_o
);
  localparam int unsigned WIDE_MSB = CNT_W - 1;
  localparam int unsigned NAR_MSB  = NAR_W - 1;

  logic [CNT_W-1:0] value_q, sum;
  logic             old_msb, new_msb;

  always_comb begin
    sum       = value_q + CNT_W'(inc_i);
    old_msb   = wide_i ? value_q[WIDE_MSB] : value_q[NAR_MSB];
    new_msb   = wide_i ? sum[WIDE_MSB]     : sum[NAR_MSB];
    ovf_hit_o = count_i && !zero_i && !load_i && old_msb && !new_msb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      value_q <= '0;
    else if (zero_i)  value_q <= '0;
    else if (load_i)  value_q <= load_val_i;
    else if (count_i) value_q <= sum;
  end

  assign value_o = value_q;

  p_zero_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (value_o == '0));

  p_load_exact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !zero_i) |=> (value_o == $past(load_val_i)));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_i && !zero_i && !load_i) |=> $stable(value_o));
endmodule

// File: rtl/ccnt_ovf_ctl.sv
module ccnt_ovf_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic sts_i,
  input  logic irq_en_i,
  output logic ovf_o,
  output logic ovf_set_o,
  output logic irq_o
);
  logic first;

  assign first = hit_i && !sts_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o     <= 1'b0;
      ovf_set_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      ovf_o     <= hit_i;
      ovf_set_o <= first;
      irq_o     <= first && irq_en_i;
    end
  end

  p_set_needs_ovf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_o |-> ovf_o);

  p_irq_needs_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_set_o);

  p_no_set_when_sts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && sts_i) |=> (ovf_o && !ovf_set_o));
endmodule

// File: rtl/ccnt_type_reg.sv
module ccnt_type_reg #(
  parameter int unsigned TYPE_W = ccnt_pkg::TYPE_W,
  parameter int unsigned FLT_W  = ccnt_pkg::FLT_W,
  parameter int unsigned EVT_W  = ccnt_pkg::EVT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [TYPE_W-1:0] wdata_i,
  output logic [TYPE_W-1:0] rdata_o
);
  localparam int unsigned GAP_W = TYPE_W - FLT_W - EVT_W;

  logic [FLT_W-1:0] flt_q;
  logic             unused_evt;

  // event field of the write is discarded: the identity is fixed
  assign unused_evt = ^wdata_i[TYPE_W-FLT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flt_q <= '0;
    else if (wr_i) flt_q <= wdata_i[TYPE_W-1:TYPE_W-FLT_W];
  end

  assign rdata_o = {flt_q, {GAP_W{1'b0}}, ccnt_pkg::CYCLE_EVT};

  p_flt_store_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o[TYPE_W-1:TYPE_W-FLT_W] == $past(wdata_i[TYPE_W-1:TYPE_W-FLT_W])));
endmodule

// File: rtl/prescaled_cycle_counter.sv
module prescaled_cycle_counter #(
  parameter int unsigned DELTA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          pass_i,
  input  logic [DELTA_W-1:0]            delta_i,
  input  logic                          div64_i,
  input  logic                          rem_clr_i,
  input  logic                          zero_i,
  input  logic                          load_i,
  input  logic [ccnt_pkg::CNT_W-1:0]    load_val_i,
  input  logic                          wide_i,
  input  logic                          ovf_sts_i,
  input  logic                          irq_en_i,
  input  logic                          type_wr_i,
  input  logic [ccnt_pkg::TYPE_W-1:0]   type_wdata_i,
  output logic [ccnt_pkg::CNT_W-1:0]    value_o,
  output logic                          ovf_o,
  output logic                          ovf_set_o,
  output logic                          irq_o,
  output logic [ccnt_pkg::TYPE_W-1:0]   type_rdata_o
);
  logic               count;
  logic [DELTA_W-1:0] inc;
  logic               hit;

  // load and zero pre-empt counting; the delta of that cycle is dropped
  assign count = en_i && pass_i && !zero_i && !load_i;

  ccnt_prescale #(.DELTA_W(DELTA_W)) u_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count),
    .div64_i   (div64_i),
    .rem_clr_i (rem_clr_i),
    .delta_i   (delta_i),
    .inc_o     (inc)
  );

  ccnt_accum #(.INC_W(DELTA_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count),
    .inc_i      (inc),
    .zero_i     (zero_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .wide_i     (wide_i),
    .value_o    (value_o),
    .ovf_hit_o  (hit)
  );

  ccnt_ovf_ctl u_ovf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .sts_i     (ovf_sts_i),
    .irq_en_i  (irq_en_i),
    .ovf_o     (ovf_o),
    .ovf_set_o (ovf_set_o),
    .irq_o     (irq_o)
  );

  ccnt_type_reg u_type (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (type_wr_i),
    .wdata_i (type_wdata_i),
    .rdata_o (type_rdata_o)
  );

  p_irq_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: tb/prescaled_cycle_counter_tb_top.sv
module prescaled_cycle_counter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 0, pass_i = 0, div64_i = 0, rem_clr_i = 0, zero_i = 0, load_i = 0;
  logic        wide_i = 0, ovf_sts_i = 0, irq_en_i = 0, type_wr_i = 0;
  logic [7:0]  delta_i = '0;
  logic [63:0] load_val_i = '0;
  logic [31:0] type_wdata_i = '0;
  logic [63:0] value_o;
  logic        ovf_o, ovf_set_o, irq_o;
  logic [31:0] type_rdata_o;

  always #5 clk_i = ~clk_i;

  prescaled_cycle_counter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pass_i(pass_i), .delta_i(delta_i),
    .div64_i(div64_i), .rem_clr_i(rem_clr_i), .zero_i(zero_i), .load_i(load_i),
    .load_val_i(load_val_i), .wide_i(wide_i), .ovf_sts_i(ovf_sts_i), .irq_en_i(irq_en_i),
    .type_wr_i(type_wr_i), .type_wdata_i(type_wdata_i), .value_o(value_o), .ovf_o(ovf_o),
    .ovf_set_o(ovf_set_o), .irq_o(irq_o), .type_rdata_o(type_rdata_o)
  );

  typedef struct {
    logic [63:0] v;
    logic        ovf, set, irq;
    logic [31:0] t;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0, n_cyc = 0;
  bit   done = 0;

  // staged stimulus
  logic        s_en = 0, s_pass = 0, s_div = 0, s_rclr = 0, s_zero = 0, s_load = 0;
  logic        s_wide = 0, s_sts = 0, s_ien = 0, s_twr = 0;
  logic [7:0]  s_d = '0;
  logic [63:0] s_lv = '0;
  logic [31:0] s_twd = '0;

  // reference state
  logic [63:0] m_val = '0;
  logic [5:0]  m_rem = '0;
  logic        m_div = 0;
  logic [7:0]  m_flt = '0;

  task automatic step(input string tag);
    exp_t e;
    logic clr, cnt, ovf, old_b, new_b;
    logic [5:0] base;
    int sumv, inc, msb;
    logic [63:0] nv;
    @(negedge clk_i);
    en_i = s_en; pass_i = s_pass; delta_i = s_d; div64_i = s_div; rem_clr_i = s_rclr;
    zero_i = s_zero; load_i = s_load; load_val_i = s_lv; wide_i = s_wide;
    ovf_sts_i = s_sts; irq_en_i = s_ien; type_wr_i = s_twr; type_wdata_i = s_twd;
    clr  = s_rclr || (s_div != m_div);
    base = clr ? 6'd0 : m_rem;
    m_div = s_div;
    cnt  = s_en && s_pass && !s_zero && !s_load;
    sumv = int'(base) + int'(s_d);
    inc  = s_div ? (sumv >> 6) : int'(s_d);
    msb  = s_wide ? 63 : 31;
    ovf  = 1'b0;
    if (s_zero) m_val = '0;
    else if (s_load) m_val = s_lv;
    else if (cnt) begin
      nv    = m_val + 64'(inc);
      old_b = m_val[msb];
      new_b = nv[msb];
      ovf   = old_b && !new_b;
      m_val = nv;
    end
    m_rem = (cnt && s_div) ? sumv[5:0] : base;
    if (s_twr) m_flt = s_twd[31:24];
    e.v = m_val; e.ovf = ovf; e.set = ovf && !s_sts; e.irq = ovf && !s_sts && s_ien;
    e.t = {m_flt, 16'h0, 8'h11}; e.tag = tag;
    q.push_back(e);
    s_rclr = 0; s_zero = 0; s_load = 0; s_twr = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (value_o !== e.v || ovf_o !== e.ovf || ovf_set_o !== e.set ||
            irq_o !== e.irq || type_rdata_o !== e.t) begin
          n_bad++;
          $display("FAIL %s: act v=%h o=%b s=%b i=%b t=%h exp v=%h o=%b s=%b i=%b t=%h",
                   e.tag, value_o, ovf_o, ovf_set_o, irq_o, type_rdata_o,
                   e.v, e.ovf, e.set, e.irq, e.t);
        end
      end
    end
  end

  task automatic chk1(input string tag, input logic ok, input logic [63:0] a, input logic [63:0] x);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %h exp %h", tag, a, x);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk_i);
      n_cyc++;
      if (n_cyc > 20000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: act %0d cycles exp completion", n_cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    // R1 reset state
    chk1("R1 value", value_o == 64'd0, value_o, 64'd0);
    chk1("R1 pulses", {ovf_o, ovf_set_o, irq_o} == 3'b000, 64'({ovf_o, ovf_set_o, irq_o}), 64'd0);
    chk1("R1 type", type_rdata_o == 32'h0000_0011, 64'(type_rdata_o), 64'h11);
    @(negedge clk_i);
    rst_ni = 1'b1;

    s_en = 1; s_pass = 1; s_ien = 1;
    s_d = 8'd5;   step("R2");
    s_d = 8'd0;   step("R2");
    s_d = 8'd200; step("R2");
    s_d = 8'd1;   step("R2");
    // R3 suppression
    s_pass = 0; s_d = 8'd50; step("R3");
    s_pass = 1; s_en = 0;    step("R3");
    s_en = 1;
    // divide mode
    s_div = 1; s_d = 8'd40;  step("R5");
    s_d = 8'd40;  step("R4");
    s_d = 8'd63;  step("R4");
    s_d = 8'd255; step("R4");
    s_pass = 0; s_d = 8'd60; step("R3");
    s_pass = 1; s_d = 8'd50; step("R3");
    s_d = 8'd60;  step("R4");
    s_div = 0; s_d = 8'd3;  step("R5");
    s_div = 1; s_d = 8'd10; step("R5");
    s_d = 8'd50;  step("R4");
    s_rclr = 1; s_d = 8'd10; step("R5");
    s_d = 8'd54;  step("R4");
    s_div = 0; s_d = 8'd1;  step("R5");
    // zero and load priority
    s_zero = 1; s_d = 8'd9; step("R6");
    s_zero = 1; s_load = 1; s_lv = 64'h1234; step("R6");
    s_load = 1; s_lv = 64'hFFFF_FFFE; s_d = 8'd5; step("R7");
    // narrow overflow
    s_d = 8'd3; step("R8");
    s_d = 8'd0; step("R8");
    s_load = 1; s_lv = 64'hFFFF_FFFF; step("R7");
    s_sts = 1; s_d = 8'd2; step("R9");
    s_sts = 0; s_load = 1; s_lv = 64'hFFFF_FFFF; step("R7");
    s_ien = 0; s_d = 8'd2; step("R10");
    s_ien = 1;
    s_load = 1; s_lv = 64'h7FFF_FFFF; step("R7");
    s_zero = 1; s_d = 8'd200; step("R6");
    // wide overflow
    s_wide = 1; s_load = 1; s_lv = 64'hFFFF_FFFF; step("R7");
    s_d = 8'd2; step("R8");
    s_load = 1; s_lv = '1; step("R7");
    s_d = 8'd2; step("R8");
    s_d = 8'd0; step("R10");
    // type register
    s_twr = 1; s_twd = 32'hA5FF_FFFF; step("R11");
    s_twr = 1; s_twd = 32'h3C00_0022; step("R11");
    step("R11");

    wait (q.size() == 0);
    repeat (2) @(posedge clk_i);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule